// File: doc/BRIEF.md
# Ethernet Transmit Fault and Idle Sequencer

This block sits in front of a 64b/66b-style transmit encoder and picks, for every cycle, which kind of code word goes out: packet data, Idle, Remote Fault or Local Fault. The choice comes from four control levels: transmit enable, a remote-fault request, a local-fault request and an idle request. The block also takes a valid/start/end handshake from an upstream packet source. It returns a ready level to that source. Its outputs are a symbolic word-kind selector, the data word that passes through, and a status level that is high while the sequencer is still initialising. The bit-level 66-bit block coding is left to the encoder that follows.

The control levels are sampled only between packets. A packet that is already in flight always runs to its end word, even if enable drops or a fault request arrives. The new control state takes effect on the cycle after that end word. Between packets the requests are resolved in a fixed order: local fault first, then remote fault, then idle, then enable.

Top module: `tx_fault_seq`

## Requirements
- R1: When the local-fault request is sampled high between packets, the next cycle emits word kind 3 (Local Fault), whatever the other control levels are.
- R2: When the remote-fault request is sampled high and the local-fault request is low between packets, the next cycle emits word kind 2 (Remote Fault).
- R3: When the idle request is sampled high and no fault request is high, the next cycle emits word kind 0 (Idle), and any beat offered in that cycle is refused.
- R4: When transmit enable is sampled low between packets with no other request, the next cycle emits Idle, and no new packet is accepted.
- R5: A packet whose start word has been accepted keeps ready high until its end word is accepted. Every beat of that packet is sent as word kind 1 (Data).
- R6: From reset the block is in an initialisation state. In that state it emits Local Fault, holds ready low and drives the status output high. It leaves that state after the first sampled cycle in which neither fault request is high.
- R7: A control change seen while a packet is open has no effect until the end word is accepted. The levels sampled in the end-word cycle govern the following cycle.
- R8: The data output equals the input word on an accepted beat and is zero in every other cycle. In data mode with no valid beat the block emits Idle.
- R9: Ready is low whenever the block is not in data mode. This includes the cycle after a packet that ended while enable was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Allow packet transmission |
| sendRemoteFault | input | 1 | Request Remote Fault words |
| sendLocalFault | input | 1 | Request Local Fault words |
| sendIdle | input | 1 | Request Idle words |
| inValid | input | 1 | Upstream beat valid |
| inStart | input | 1 | Beat is the first word of a packet |
| inEnd | input | 1 | Beat is the last word of a packet |
| inData | input | DATA_W | Upstream data word |
| inReady | output | 1 | Beat accepted when high together with inValid |
| outType | output | 2 | Word kind: 0 Idle, 1 Data, 2 Remote Fault, 3 Local Fault |
| outData | output | DATA_W | Data word for the encoder, zero unless a beat is accepted |
| localFaultStatus | output | 1 | High while in the initialisation state |

## Verification
The bench builds the block with its default 64-bit data width. This lets it use distinct full-width words to show that data passes through on accepted beats and is forced to zero on refused ones. The bench leaves reset with a local-fault request and then a remote-fault request pending, so the exit from initialisation can be seen. It drops enable and raises fault requests in the middle of packets to show that the requests are deferred to the end word. It also sends a single-beat packet, where the start and end words fall in the same cycle.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

  typedef enum logic [1:0] {
    WORD_IDLE   = 2'd0,
    WORD_DATA   = 2'd1,
    WORD_RFAULT = 2'd2,
    WORD_LFAULT = 2'd3
  } wordKind_e;

  typedef enum logic [2:0] {
    MODE_INIT,
    MODE_DATA,
    MODE_IDLE,
    MODE_RF,
    MODE_LF
  } txMode_e;

  typedef struct packed {
    logic      dataWin;
    wordKind_e fillKind;
  } seqStrobe_t;

endpackage

// File: rtl/txseq_ctrl.sv
module txseq_ctrl
  import txseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic       sendRf,
  input  logic       sendLf,
  input  logic       sendIdle,
  input  logic       inValid,
  input  logic       inStart,
  input  logic       inEnd,
  output seqStrobe_t strb,
  output logic       inReady,
  output logic       pktOpen,
  output logic       localFaultStatus
);

  txMode_e modeQ, prioMode, nextMode;
  logic    pktOpenQ, pktNext, beat, updEn;

  assign inReady = (modeQ == MODE_DATA);
  assign beat    = inValid && inReady;

  always_comb begin
    pktNext = pktOpenQ;
    if (beat) begin
      if (inEnd)        pktNext = 1'b0;
      else if (inStart) pktNext = 1'b1;
    end
  end

  // sample controls only when no packet stays open after this cycle
  assign updEn = !pktNext;

  always_comb begin
    if (sendLf)         prioMode = MODE_LF;
    else if (sendRf)    prioMode = MODE_RF;
    else if (sendIdle)  prioMode = MODE_IDLE;
    else if (!txEnable) prioMode = MODE_IDLE;
    else                prioMode = MODE_DATA;
  end

  always_comb begin
    if (modeQ == MODE_INIT && (sendLf || sendRf)) nextMode = MODE_INIT;
    else                                           nextMode = prioMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= MODE_INIT;
      pktOpenQ <= 1'b0;
    end else begin
      pktOpenQ <= pktNext;
      if (updEn) modeQ <= nextMode;
    end
  end

  always_comb begin
    strb.dataWin = (modeQ == MODE_DATA);
    unique case (modeQ)
      MODE_INIT, MODE_LF: strb.fillKind = WORD_LFAULT;
      MODE_RF:            strb.fillKind = WORD_RFAULT;
      default:            strb.fillKind = WORD_IDLE;
    endcase
  end

  assign pktOpen          = pktOpenQ;
  assign localFaultStatus = (modeQ == MODE_INIT);

endmodule

// File: rtl/txseq_dpath.sv
module txseq_dpath
  import txseq_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  seqStrobe_t        strb,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic [1:0]        outKind,
  output logic [DATA_W-1:0] outData
);

  logic beat;
  assign beat = strb.dataWin && inValid;

  always_comb begin
    if (beat)              outKind = WORD_DATA;
    else if (strb.dataWin) outKind = WORD_IDLE;
    else                   outKind = strb.fillKind;
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_gate
    assign outData[b] = inData[b] & beat;
  end

endmodule

// File: rtl/tx_fault_seq.sv
module tx_fault_seq
  import txseq_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              sendRemoteFault,
  input  logic              sendLocalFault,
  input  logic              sendIdle,
  input  logic              inValid,
  input  logic              inStart,
  input  logic              inEnd,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic [1:0]        outType,
  output logic [DATA_W-1:0] outData,
  output logic              localFaultStatus
);

  seqStrobe_t strb;
  logic       pktOpen;

  txseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .sendRf(sendRemoteFault),
    .sendLf(sendLocalFault), .sendIdle(sendIdle), .inValid(inValid),
    .inStart(inStart), .inEnd(inEnd), .strb(strb), .inReady(inReady),
    .pktOpen(pktOpen), .localFaultStatus(localFaultStatus)
  );

  txseq_dpath #(.DATA_W(DATA_W)) u_dpath (
    .strb(strb), .inValid(inValid), .inData(inData),
    .outKind(outType), .outData(outData)
  );

endmodule

// File: rtl/tx_fault_seq_chk.sv
module tx_fault_seq_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              sendRemoteFault,
  input logic              sendLocalFault,
  input logic              inValid,
  input logic              inReady,
  input logic [1:0]        outType,
  input logic [DATA_W-1:0] outData,
  input logic              localFaultStatus,
  input logic              pktOpen
);

  logic beat;
  assign beat = inValid && inReady;

  a_r1_lf_wins: assert property (@(posedge clk) disable iff (!rstN)
    (!pktOpen && !beat && sendLocalFault) |=> outType == 2'd3);

  a_r2_rf_next: assert property (@(posedge clk) disable iff (!rstN)
    (!pktOpen && !beat && sendRemoteFault && !sendLocalFault && !localFaultStatus)
      |=> outType == 2'd2);

  a_r5_open_ready: assert property (@(posedge clk) disable iff (!rstN)
    pktOpen |-> inReady);

  a_r6_init_lf: assert property (@(posedge clk) disable iff (!rstN)
    localFaultStatus |-> (outType == 2'd3 && !inReady));

  a_r8_data_gate: assert property (@(posedge clk) disable iff (!rstN)
    !beat |-> outData == '0);

  a_r9_fault_noready: assert property (@(posedge clk) disable iff (!rstN)
    (outType[1]) |-> !inReady);

endmodule

bind tx_fault_seq tx_fault_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .sendRemoteFault(sendRemoteFault),
  .sendLocalFault(sendLocalFault), .inValid(inValid), .inReady(inReady),
  .outType(outType), .outData(outData), .localFaultStatus(localFaultStatus),
  .pktOpen(pktOpen)
);

// File: tb/tx_fault_seq_bench.sv
`timescale 1ns/100ps
module tx_fault_seq_bench;

  localparam int DW = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEnable = 1'b0, sendRemoteFault = 1'b0, sendLocalFault = 1'b0, sendIdle = 1'b0;
  logic inValid = 1'b0, inStart = 1'b0, inEnd = 1'b0;
  logic [DW-1:0] inData = '0;
  logic inReady, localFaultStatus;
  logic [1:0] outType;
  logic [DW-1:0] outData;

  always #2 clk = ~clk;

  tx_fault_seq #(.DATA_W(DW)) u_tx_fault_seq (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .sendRemoteFault(sendRemoteFault),
    .sendLocalFault(sendLocalFault), .sendIdle(sendIdle), .inValid(inValid),
    .inStart(inStart), .inEnd(inEnd), .inData(inData), .inReady(inReady),
    .outType(outType), .outData(outData), .localFaultStatus(localFaultStatus)
  );

  typedef struct {
    logic [1:0]    kind;
    logic          rdy;
    logic          lfs;
    logic [DW-1:0] data;
    string         tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  task automatic step(input bit en, rf, lf, id, v, s, e, input logic [DW-1:0] d,
                      input logic [1:0] xk, input bit xr, xl,
                      input logic [DW-1:0] xd, input string tag);
    expItem_t it;
    @(negedge clk);
    txEnable = en; sendRemoteFault = rf; sendLocalFault = lf; sendIdle = id;
    inValid = v; inStart = s; inEnd = e; inData = d;
    it.kind = xk; it.rdy = xr; it.lfs = xl; it.data = xd; it.tag = tag;
    expQ.push_back(it);
  endtask

  initial begin : monitor
    expItem_t it;
    forever begin
      @(negedge clk);
      #0.5;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        checks++;
        if (outType !== it.kind) begin
          failures++;
          $display("FAIL %s outType actual=%0d expected=%0d", it.tag, outType, it.kind);
        end
        checks++;
        if (inReady !== it.rdy) begin
          failures++;
          $display("FAIL %s inReady actual=%0b expected=%0b", it.tag, inReady, it.rdy);
        end
        checks++;
        if (localFaultStatus !== it.lfs) begin
          failures++;
          $display("FAIL %s localFaultStatus actual=%0b expected=%0b", it.tag, localFaultStatus, it.lfs);
        end
        checks++;
        if (outData !== it.data) begin
          failures++;
          $display("FAIL %s outData actual=%h expected=%h", it.tag, outData, it.data);
        end
      end
    end
  end

  initial begin : watchdog
    #800000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    // reset state (R6)
    step(0,0,1,0, 0,0,0, 64'h0, 2'd3,0,1, 64'h0, "R6 reset");
    step(0,0,1,0, 1,1,0, 64'hdead, 2'd3,0,1, 64'h0, "R6 reset beat refused");
    rstN = 1'b1;
    step(0,0,1,0, 0,0,0, 64'h0, 2'd3,0,1, 64'h0, "R6 init lf pending");
    step(1,1,0,0, 0,0,0, 64'h0, 2'd3,0,1, 64'h0, "R6 init still");
    step(1,0,0,0, 0,0,0, 64'h0, 2'd3,0,1, 64'h0, "R6 init rf pending");
    step(1,0,0,0, 0,0,0, 64'h0, 2'd0,1,0, 64'h0, "R6 left init, R8 idle in data mode");
    // packet with enable drop and lf mid-packet
    step(1,0,0,0, 1,1,0, 64'hA1A1_0000_1111_2222, 2'd1,1,0, 64'hA1A1_0000_1111_2222, "R8 start beat");
    step(0,0,1,0, 1,0,0, 64'hA2A2_3333_4444_5555, 2'd1,1,0, 64'hA2A2_3333_4444_5555, "R5 R7 mid beat held");
    step(0,0,1,0, 1,0,1, 64'hA3A3_6666_7777_8888, 2'd1,1,0, 64'hA3A3_6666_7777_8888, "R5 end beat");
    step(1,1,0,0, 0,0,0, 64'h0, 2'd3,0,0, 64'h0, "R7 R1 lf after end");
    step(1,0,0,0, 1,1,0, 64'hBBBB, 2'd2,0,0, 64'h0, "R2 rf words");
    step(1,0,0,1, 0,0,0, 64'h0, 2'd0,1,0, 64'h0, "R8 data mode idle");
    step(1,0,0,0, 1,1,0, 64'hCCCC, 2'd0,0,0, 64'h0, "R3 idle request");
    step(0,0,0,0, 0,0,0, 64'h0, 2'd0,1,0, 64'h0, "R8 data mode idle");
    step(1,1,1,0, 1,1,0, 64'hDDDD, 2'd0,0,0, 64'h0, "R4 enable low");
    step(1,0,0,0, 0,0,0, 64'h0, 2'd3,0,0, 64'h0, "R1 lf over rf");
    // single-beat packet, then rf raised mid-packet
    step(1,0,0,0, 1,1,1, 64'h0123_4567_89AB_CDEF, 2'd1,1,0, 64'h0123_4567_89AB_CDEF, "R8 single beat");
    step(1,0,0,0, 1,1,0, 64'hD1, 2'd1,1,0, 64'hD1, "R5 start");
    step(1,1,0,0, 1,0,0, 64'hD2, 2'd1,1,0, 64'hD2, "R7 rf deferred");
    step(1,1,0,0, 1,0,1, 64'hD3, 2'd1,1,0, 64'hD3, "R7 end beat");
    step(1,0,0,0, 0,0,0, 64'h0, 2'd2,0,0, 64'h0, "R7 R2 rf after end");
    step(1,0,0,0, 0,0,0, 64'h0, 2'd0,1,0, 64'h0, "R8 back to data mode");
    // enable dropped in last beat only
    step(1,0,0,0, 1,1,0, 64'hE1, 2'd1,1,0, 64'hE1, "R5 start");
    step(0,0,0,0, 1,0,1, 64'hE2, 2'd1,1,0, 64'hE2, "R5 end with enable low");
    step(1,0,0,0, 1,1,0, 64'hE3, 2'd0,0,0, 64'h0, "R9 no ready after drop");
    step(1,0,0,0, 0,0,0, 64'h0, 2'd0,1,0, 64'h0, "R4 resume data mode");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule